// File: doc/BRIEF.md
# Internal Data RAM Controller for an 8-bit Accumulator Core

This block holds the 256-byte scratch memory of a small 8-bit core and serves every way the core reaches it. A byte can be named directly by address or reached through a pointer. A register can be named by its number within the bank selected by the core's status word. A single bit of the bit-addressable window can be read or written. A value can be pushed onto or popped off the hardware stack. The block keeps the stack pointer and exposes it.

Requests arrive on a valid/ready channel: one operation code, one address byte, the bank select and the write data. Every accepted request produces exactly one response beat carrying read data and an SFR flag. A direct or bit access whose address has its top bit set belongs to the special-function register space and not to RAM. For such an access the block raises the SFR flag, leaves RAM alone and returns zero, so that the neighbouring register file can serve it. A response that is not taken is held unchanged, and while it waits no new request is accepted. RAM contents survive reset. Only the stack pointer and the response channel are reset.

Top module: `iram_ctrl`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `stack_ptr` is 0x07.
- R2: Op code 0 reads the byte at `req_addr` and op code 1 writes `req_wdata` to it, both when `req_addr` < 0x80. The response has `rsp_sfr` = 0.
- R3: An op code 0 or 1 request with `req_addr` >= 0x80 responds with `rsp_sfr` = 1 and `rsp_data` = 0, and leaves every RAM byte unchanged.
- R4: Op code 2 reads and op code 3 writes the byte at any `req_addr` from 0x00 to 0xFF, with `rsp_sfr` = 0.
- R5: Op code 4 reads and op code 5 writes register `req_addr[2:0]` of bank `req_bank`. That register is the byte at `req_bank`*8 + `req_addr[2:0]`.
- R6: Op code 6 with `req_addr` < 0x80 returns, in `rsp_data[0]`, bit `req_addr[2:0]` of byte 0x20 + `req_addr[6:3]`. `rsp_data[7:1]` is 0. For example, bit address 0x13 is bit 3 of byte 0x22.
- R7: Op code 7 with `req_addr` < 0x80 sets that same bit to `req_wdata[0]` and leaves the other seven bits of the byte unchanged.
- R8: An op code 6 or 7 request with `req_addr` >= 0x80 responds with `rsp_sfr` = 1 and `rsp_data` = 0, and changes no RAM byte.
- R9: Op code 8 (push) first increments `stack_ptr` modulo 256 and then writes `req_wdata` at the new value, so the first push after reset lands at 0x08. No request other than a push or a pop changes `stack_ptr`.
- R10: Op code 9 (pop) returns the byte at the current `stack_ptr` and then decrements `stack_ptr` modulo 256, so a pop at 0x00 leaves 0xFF.
- R11: `req_ready` is high exactly when no response is pending or the pending one is being taken. A request is accepted when `req_valid` and `req_ready` are both high, and its response appears on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds its data and flag. Writes, pushes and unused op codes 10 to 15 respond with `rsp_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 4 | Operation code (see requirements) |
| req_addr | input | 8 | Byte, pointer, register or bit address |
| req_bank | input | 2 | Active register bank |
| req_wdata | input | 8 | Write or push data; bit writes use bit 0 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_data | output | 8 | Read, bit or pop result |
| rsp_sfr | output | 1 | Access belongs to special-function register space |
| stack_ptr | output | 8 | Current stack pointer |

## Verification
The whole array is first filled through pointer writes with an address-dependent pattern. Every later read can then be told apart from a read of the wrong byte. Direct reads and writes are aimed both below and above 0x80, and each upper case is followed by a pointer read of the same byte, which shows that the SFR branch kept its hands off RAM. Register ops walk all four banks, and the results are read back through pointers to confirm the bank offset. Bit writes that set and clear single bits are checked against whole-byte reads of their container. A pop run walks the stack pointer past 0x00 and a push brings it back, exercising both wraps. A final mixed burst runs with `rsp_ready` toggling pseudo-randomly, so back-pressure, held responses and accept timing are compared against the model on every clock.

// File: rtl/iram_pkg.sv
package iram_pkg;

  typedef enum logic [3:0] {
    OP_DIR_RD  = 4'd0,
    OP_DIR_WR  = 4'd1,
    OP_PTR_RD  = 4'd2,
    OP_PTR_WR  = 4'd3,
    OP_REG_RD  = 4'd4,
    OP_REG_WR  = 4'd5,
    OP_BIT_RD  = 4'd6,
    OP_BIT_WR  = 4'd7,
    OP_PUSH    = 4'd8,
    OP_POP     = 4'd9
  } iram_op_e;

endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BANK_W   = 2,
  parameter int REG_W    = 3,
  parameter int BPOS_W   = 3,
  parameter int BIT_BASE = 32
) (
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] tgt,
  output logic [BPOS_W-1:0] bpos,
  output logic              rd_en,
  output logic              wr_en,
  output logic              bit_op,
  output logic              sfr,
  output logic              sp_inc,
  output logic              sp_dec
);
  localparam int REG_PAD = ADDR_W - BANK_W - REG_W;

  logic upper;
  assign upper = addr[ADDR_W-1];

  always_comb begin
    tgt    = '0;
    bpos   = addr[BPOS_W-1:0];
    rd_en  = 1'b0;
    wr_en  = 1'b0;
    bit_op = 1'b0;
    sfr    = 1'b0;
    sp_inc = 1'b0;
    sp_dec = 1'b0;
    case (op)
      OP_DIR_RD, OP_DIR_WR: begin
        tgt   = addr;
        sfr   = upper;
        rd_en = (op == OP_DIR_RD) && !upper;
        wr_en = (op == OP_DIR_WR) && !upper;
      end
      OP_PTR_RD: begin tgt = addr; rd_en = 1'b1; end
      OP_PTR_WR: begin tgt = addr; wr_en = 1'b1; end
      OP_REG_RD, OP_REG_WR: begin
        tgt   = {{REG_PAD{1'b0}}, bank, addr[REG_W-1:0]};
        rd_en = (op == OP_REG_RD);
        wr_en = (op == OP_REG_WR);
      end
      OP_BIT_RD, OP_BIT_WR: begin
        tgt    = ADDR_W'(BIT_BASE) + ADDR_W'(addr[ADDR_W-2:BPOS_W]);
        sfr    = upper;
        bit_op = 1'b1;
        rd_en  = !upper;
        wr_en  = (op == OP_BIT_WR) && !upper;
      end
      OP_PUSH: begin
        tgt    = sp + ADDR_W'(1);
        wr_en  = 1'b1;
        sp_inc = 1'b1;
      end
      OP_POP: begin
        tgt    = sp;
        rd_en  = 1'b1;
        sp_dec = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/iram_stack.sv
module iram_stack #(
  parameter int ADDR_W   = 8,
  parameter int SP_RESET = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [ADDR_W-1:0] sp
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= ADDR_W'(SP_RESET);
    else if (inc) sp <= sp + ADDR_W'(1);
    else if (dec) sp <= sp - ADDR_W'(1);
  end
endmodule

// File: rtl/iram_ctrl.sv
module iram_ctrl
  import iram_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter int REG_W    = 3,
  parameter int SP_RESET = 7,
  parameter int BIT_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_sfr,
  output logic [ADDR_W-1:0] stack_ptr
);
  localparam int BPOS_W = $clog2(DATA_W);

  logic              accept;
  logic [ADDR_W-1:0] tgt;
  logic [BPOS_W-1:0] bpos;
  logic              rd_en, wr_en, bit_op, sfr, sp_inc, sp_dec;
  logic [DATA_W-1:0] cur_byte, merged, store_data, rd_result;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  iram_addr_map #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W),
    .BPOS_W(BPOS_W), .BIT_BASE(BIT_BASE)
  ) u_map (
    .op(req_op), .addr(req_addr), .bank(req_bank), .sp(stack_ptr),
    .tgt(tgt), .bpos(bpos), .rd_en(rd_en), .wr_en(wr_en),
    .bit_op(bit_op), .sfr(sfr), .sp_inc(sp_inc), .sp_dec(sp_dec)
  );

  always_comb begin
    merged       = cur_byte;
    merged[bpos] = req_wdata[0];
  end

  assign store_data = bit_op ? merged : req_wdata;

  iram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(accept && wr_en), .addr(tgt),
    .wdata(store_data), .rdata(cur_byte)
  );

  iram_stack #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .inc(accept && sp_inc), .dec(accept && sp_dec), .sp(stack_ptr)
  );

  always_comb begin
    rd_result = '0;
    if (rd_en && !wr_en) begin
      if (bit_op) rd_result = DATA_W'(cur_byte[bpos]);
      else        rd_result = cur_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_sfr   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_result;
      rsp_sfr   <= sfr;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iram_ctrl_chk.sv
module iram_ctrl_chk
  import iram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_sfr,
  input logic [ADDR_W-1:0] stack_ptr
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_sfr));

  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R9
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_PUSH |=> stack_ptr == ADDR_W'($past(stack_ptr) + 1'b1));

  // R10
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_POP |=> stack_ptr == ADDR_W'($past(stack_ptr) - 1'b1));

  // R9
  sp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && (req_op == OP_PUSH || req_op == OP_POP)) |=> $stable(stack_ptr));

  // R3
  dir_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_op == OP_DIR_RD || req_op == OP_DIR_WR) && req_addr[ADDR_W-1]
      |=> rsp_sfr && rsp_data == '0);

  // R4
  ptr_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_op == OP_PTR_RD || req_op == OP_PTR_WR) |=> !rsp_sfr);

  // R6
  bit_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_BIT_RD |=> rsp_data[DATA_W-1:1] == '0);
endmodule

bind iram_ctrl iram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_sfr(rsp_sfr),
  .stack_ptr(stack_ptr)
);

// File: tb/sim_iram_ctrl.sv
`timescale 1ns/1ps
module sim_iram_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_op = 4'd0;
  logic [7:0] req_addr = 8'd0;
  logic [1:0] req_bank = 2'd0;
  logic [7:0] req_wdata = 8'd0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       rsp_sfr;
  logic [7:0] stack_ptr;

  always #2.5 clk = ~clk;

  iram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_bank(req_bank),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_sfr(rsp_sfr), .stack_ptr(stack_ptr)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  int    mem [256];
  bit    known [256];
  int    m_sp = 7;
  bit    m_rv = 0;
  bit    m_sfr = 0;
  int    m_data = 0;
  bit    m_known = 1;
  string m_tag = "R1";
  bit    stall_en = 0;
  logic [7:0] lfsr = 8'hA5;
  bit    done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rv = 0; m_sp = 7;
    end else if (req_valid && (!m_rv || rsp_ready)) begin
      int a, idx, b;
      a = req_addr;
      m_rv = 1; m_sfr = 0; m_data = 0; m_known = 1;
      case (req_op)
        4'd0: begin
          m_tag = (a >= 128) ? "R3" : "R2";
          if (a >= 128) m_sfr = 1;
          else begin m_data = mem[a]; m_known = known[a]; end
        end
        4'd1: begin
          m_tag = (a >= 128) ? "R3" : "R2";
          if (a >= 128) m_sfr = 1;
          else begin mem[a] = req_wdata; known[a] = 1; end
        end
        4'd2: begin m_tag = "R4"; m_data = mem[a]; m_known = known[a]; end
        4'd3: begin m_tag = "R4"; mem[a] = req_wdata; known[a] = 1; end
        4'd4: begin
          m_tag = "R5"; idx = req_bank * 8 + a % 8;
          m_data = mem[idx]; m_known = known[idx];
        end
        4'd5: begin
          m_tag = "R5"; idx = req_bank * 8 + a % 8;
          mem[idx] = req_wdata; known[idx] = 1;
        end
        4'd6: begin
          if (a >= 128) begin m_tag = "R8"; m_sfr = 1; end
          else begin
            m_tag = "R6"; idx = 32 + a / 8; b = a % 8;
            m_data = (mem[idx] >> b) & 1; m_known = known[idx];
          end
        end
        4'd7: begin
          if (a >= 128) begin m_tag = "R8"; m_sfr = 1; end
          else begin
            m_tag = "R7"; idx = 32 + a / 8; b = a % 8;
            mem[idx] = (mem[idx] & ~(1 << b)) | ((req_wdata & 1) << b);
          end
        end
        4'd8: begin
          m_tag = "R9"; m_sp = (m_sp + 1) % 256;
          mem[m_sp] = req_wdata; known[m_sp] = 1;
        end
        4'd9: begin
          m_tag = "R10"; m_data = mem[m_sp]; m_known = known[m_sp];
          m_sp = (m_sp + 255) % 256;
        end
        default: m_tag = "R11";
      endcase
    end else if (rsp_ready) begin
      m_rv = 0;
    end
  end

  // Per-clock comparison, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(req_ready == (!m_rv || rsp_ready), "R11", req_ready, !m_rv || rsp_ready);
      chk(rsp_valid == m_rv, "R11", rsp_valid, m_rv);
      chk(stack_ptr == m_sp[7:0], (m_tag == "R10") ? "R10" : "R9", stack_ptr, m_sp);
      if (m_rv) begin
        chk(rsp_sfr == m_sfr, m_tag, rsp_sfr, m_sfr);
        if (m_known) chk(rsp_data == m_data[7:0], m_tag, rsp_data, m_data);
      end
    end
  end

  task automatic set_ready();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready = stall_en ? lfsr[0] : 1'b1;
  endtask

  task automatic send(input int op, input int addr, input int bank, input int wd);
    bit acc;
    req_op = op[3:0]; req_addr = addr[7:0]; req_bank = bank[1:0];
    req_wdata = wd[7:0]; req_valid = 1'b1;
    forever begin
      #1;
      acc = req_ready;
      @(negedge clk);
      set_ready();
      if (acc) break;
    end
    req_valid = 1'b0;
  endtask

  initial begin
    int wd_cnt;
    wd_cnt = 0;
    forever begin
      @(posedge clk);
      wd_cnt++;
      if (wd_cnt > 100000 && !done) begin
        done = 1;
        n_vec++; n_bad++;
        $display("FAIL R11 watchdog expired actual=0x0 expected=0x1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 0; known[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1", rsp_valid, 0);
    chk(stack_ptr == 8'h07, "R1", stack_ptr, 7);
    @(negedge clk);

    // R4: fill every byte through the pointer path, then sample reads
    for (int i = 0; i < 256; i++) send(3, i, 0, i ^ 8'h5A);
    for (int i = 0; i < 256; i += 17) send(2, i, 0, 0);
    send(2, 255, 0, 0);

    // R2: direct lower half
    send(1, 8'h45, 0, 8'hC3);
    send(0, 8'h45, 0, 0);
    send(2, 8'h45, 0, 0);
    send(0, 8'h7F, 0, 0);

    // R3: direct upper half goes to SFR space, RAM untouched
    send(1, 8'h90, 0, 8'h99);
    send(0, 8'h90, 0, 0);
    send(2, 8'h90, 0, 0);
    send(1, 8'h80, 0, 8'h11);
    send(2, 8'h80, 0, 0);

    // R5: registers in every bank
    for (int b = 0; b < 4; b++) begin
      send(5, 3, b, 8'hB0 + b);
      send(4, 3, b, 0);
      send(2, b * 8 + 3, 0, 0);
      send(5, 8'hF7, b, 8'hE0 + b);
      send(2, b * 8 + 7, 0, 0);
    end

    // R6/R7: bit access
    send(3, 8'h22, 0, 8'h00);
    send(7, 8'h13, 0, 1);
    send(2, 8'h22, 0, 0);
    send(6, 8'h13, 0, 0);
    send(6, 8'h12, 0, 0);
    send(3, 8'h2F, 0, 8'hFF);
    send(7, 8'h7D, 0, 0);
    send(2, 8'h2F, 0, 0);
    send(6, 8'h7D, 0, 0);
    send(6, 8'h7F, 0, 0);
    send(7, 8'h00, 0, 0);
    send(2, 8'h20, 0, 0);

    // R8: bit access into SFR space
    send(7, 8'h85, 0, 1);
    send(6, 8'h85, 0, 0);
    send(2, 8'h20, 0, 0);
    send(2, 8'h30, 0, 0);

    // R9/R10: stack order and wrap
    send(8, 0, 0, 8'h31);
    send(2, 8'h08, 0, 0);
    send(8, 0, 0, 8'h32);
    send(8, 0, 0, 8'h33);
    send(9, 0, 0, 0);
    send(9, 0, 0, 0);
    send(9, 0, 0, 0);
    for (int i = 0; i < 8; i++) send(9, 0, 0, 0);
    send(8, 0, 0, 8'h44);
    send(2, 8'h00, 0, 0);
    send(9, 0, 0, 0);
    send(9, 0, 0, 0);
    send(8, 0, 0, 8'h55);
    send(2, 8'hFF, 0, 0);
    send(12, 8'h10, 0, 0);

    // R11: mixed traffic under back-pressure
    stall_en = 1;
    for (int i = 0; i < 300; i++) begin
      int op;
      op = (i * 7 + 3) % 11;
      if (op == 10) op = 13;
      send(op, (i * 37 + 5) % 256, i % 4, (i * 11) % 256);
    end
    stall_en = 0;
    repeat (4) begin @(negedge clk); set_ready(); end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule